// File: doc/BRIEF.md
# Receive Buffer Area Sequencer

This block decides, packet by packet, how received frames are packed into receive buffer areas in system memory. When a packet ends, the receive path sends a done strobe together with the number of words still free in the current buffer area. The block compares that count with a programmable end-of-buffer threshold. If enough room is left, the next packet is placed in the same area. If not, the block marks the packet just finished as the last one of its area and asks for the next resource descriptor. It holds that request until the descriptor fetch logic acknowledges it.

The block also keeps a 16-bit sequence word. It is made of two modulo-256 counters: one numbers the packets within the current buffer area and the other numbers the buffer areas. Software reaches the threshold and the sequence word through a small register port that reads back combinationally.

The control is a two-state machine. `ST_FILL` means packets are being packed into the current area. `ST_FETCH` means the current area is closed and a descriptor fetch is pending. The transition FILL→FETCH is taken when a packet is accepted and the threshold exceeds the remaining count, unless a software reset is present in that cycle. The transition FETCH→FILL is taken when `fetch_ack` arrives or when a software reset is applied. In every other case the machine stays in its current state.

Top module: `rba_sequencer`

## Requirements
- R1: A packet-done strobe seen in ST_FILL whose remaining count is greater than or equal to the threshold leaves `last_pkt` and `fetch_req` low, so the next packet shares the current area.
- R2: A packet-done strobe seen in ST_FILL whose remaining count is less than the threshold raises both `last_pkt` and `fetch_req` from the next clock edge.
- R3: The active-low hardware reset loads the threshold with 0x02F8 (760 words), clears the sequence word to 0x0000 and drops `last_pkt` and `fetch_req`.
- R4: Register address 0 reads the threshold. Address 1 reads the sequence word, with the packet number in bits 7:0 and the buffer number in bits 15:8. Addresses 2 and 3 read zero and ignore writes.
- R5: Each packet-done strobe accepted in ST_FILL adds one to the packet number modulo 256, leaving the buffer number unchanged.
- R6: An acknowledge in ST_FETCH clears the packet number, adds one to the buffer number modulo 256, and drops `last_pkt` and `fetch_req` at that same edge.
- R7: `last_pkt` stays high until the acknowledge. Packet-done strobes that arrive while it is high change no counter.
- R8: A software reset returns the machine to ST_FILL and clears a pending request, but leaves the threshold and the sequence word unchanged.
- R9: A write to address 1 loads the sequence word and overrides any counter update in the same cycle. Writing zero clears it.
- R10: A write to address 0 sets the threshold used by every packet that ends from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset, clears only the control state |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 threshold, 1 sequence word) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| pkt_done | input | 1 | Packet reception finished |
| pkt_rem_words | input | 16 | Words left in the current buffer area, valid with `pkt_done` |
| last_pkt | output | 1 | The finished packet was the last in its buffer area |
| fetch_req | output | 1 | Request for the next resource descriptor |
| fetch_ack | input | 1 | Descriptor fetch done |

## Verification
The bench targets the equality point of the comparison (remaining count equal to the threshold, and one below it). A design that compares the wrong way round, or uses a strict comparison, would close a buffer area one packet early or one packet late. It also wraps both counters through 255. A design with the wrong field width or the wrong carry would either let a packet wrap spill into the buffer number or skip zero. It also drives a register write, a done strobe and an acknowledge into the same cycle. A design that lets the counter win over the write would read back an incremented value instead of the written one. Finally, it issues a software reset while a fetch is pending. A design that clears the counters on that reset would lose the numbering, and one that ignores the reset would keep `fetch_req` high.

// File: rtl/rba_seq_pkg.sv
package rba_seq_pkg;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_FETCH = 1'b1
    } rba_state_e;

    localparam int FIELD_PKT = 0;
    localparam int FIELD_BUF = 1;
    localparam int NUM_FIELDS = 2;

endpackage

// File: rtl/rba_seq_thresh.sv
module rba_seq_thresh #(
    parameter int          DATA_W    = 16,
    parameter logic [15:0] RESET_VAL = 16'h02F8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rem_words,
    output logic [DATA_W-1:0] thr_q,
    output logic              need_new
);

    localparam logic [DATA_W-1:0] RST_V = DATA_W'(RESET_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= RST_V;
        end else if (wr_en) begin
            thr_q <= wdata;
        end
    end

    // A new area is needed when the free room falls below the threshold
    always_comb begin
        need_new = (thr_q > rem_words);
    end

endmodule

// File: rtl/rba_seq_field.sv
module rba_seq_field #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val
);

    localparam logic [W-1:0] ONE = W'(1);

    // Priority: software load, then clear, then increment (wraps naturally)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= '0;
        end else if (load) begin
            val <= load_val;
        end else if (clr) begin
            val <= '0;
        end else if (inc) begin
            val <= val + ONE;
        end
    end

endmodule

// File: rtl/rba_seq_fsm.sv
module rba_seq_fsm
    import rba_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic pkt_done,
    input  logic need_new,
    input  logic fetch_ack,
    output logic pkt_accept,
    output logic buf_take,
    output logic last_pkt,
    output logic fetch_req
);

    rba_state_e state_q;
    rba_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (!soft_rst && pkt_done && need_new) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (soft_rst || fetch_ack) begin
                    state_d = ST_FILL;
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    always_comb begin
        pkt_accept = 1'b0;
        buf_take   = 1'b0;
        last_pkt   = 1'b0;
        fetch_req  = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                pkt_accept = pkt_done;
            end
            ST_FETCH: begin
                last_pkt  = 1'b1;
                fetch_req = 1'b1;
                buf_take  = fetch_ack;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rba_sequencer.sv
module rba_sequencer
    import rba_seq_pkg::*;
#(
    parameter int          SEQ_W     = 8,
    parameter int          ADDR_W    = 2,
    parameter int          ADDR_THR  = 0,
    parameter int          ADDR_SEQ  = 1,
    parameter logic [15:0] THR_RESET = 16'h02F8,
    localparam int         DATA_W    = NUM_FIELDS * SEQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pkt_done,
    input  logic [DATA_W-1:0] pkt_rem_words,
    output logic              last_pkt,
    output logic              fetch_req,
    input  logic              fetch_ack
);

    localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(ADDR_THR);
    localparam logic [ADDR_W-1:0] A_SEQ = ADDR_W'(ADDR_SEQ);

    logic              wr_thr;
    logic              wr_seq;
    logic [DATA_W-1:0] thr_q;
    logic [DATA_W-1:0] seq_word;
    logic              need_new;
    logic              pkt_accept;
    logic              buf_take;
    logic              f_clr [NUM_FIELDS];
    logic              f_inc [NUM_FIELDS];

    always_comb begin
        wr_thr = reg_wr && (reg_addr == A_THR);
        wr_seq = reg_wr && (reg_addr == A_SEQ);
    end

    rba_seq_thresh #(
        .DATA_W   (DATA_W),
        .RESET_VAL(THR_RESET)
    ) u_thresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_thr),
        .wdata    (reg_wdata),
        .rem_words(pkt_rem_words),
        .thr_q    (thr_q),
        .need_new (need_new)
    );

    rba_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .pkt_done  (pkt_done),
        .need_new  (need_new),
        .fetch_ack (fetch_ack),
        .pkt_accept(pkt_accept),
        .buf_take  (buf_take),
        .last_pkt  (last_pkt),
        .fetch_req (fetch_req)
    );

    // Packet field counts accepted packets and clears on a new area;
    // buffer field counts new areas.
    always_comb begin
        f_clr[FIELD_PKT] = buf_take;
        f_inc[FIELD_PKT] = pkt_accept;
        f_clr[FIELD_BUF] = 1'b0;
        f_inc[FIELD_BUF] = buf_take;
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        rba_seq_field #(
            .W(SEQ_W)
        ) u_field (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (wr_seq),
            .load_val(reg_wdata[g*SEQ_W +: SEQ_W]),
            .clr     (f_clr[g]),
            .inc     (f_inc[g]),
            .val     (seq_word[g*SEQ_W +: SEQ_W])
        );
    end

    always_comb begin
        if (reg_addr == A_THR) begin
            reg_rdata = thr_q;
        end else if (reg_addr == A_SEQ) begin
            reg_rdata = seq_word;
        end else begin
            reg_rdata = '0;
        end
    end

endmodule

// File: rtl/rba_seq_checker.sv
module rba_seq_checker #(
    parameter int SEQ_W    = 8,
    parameter int ADDR_W   = 2,
    parameter int ADDR_SEQ = 1,
    parameter int DATA_W   = 2 * SEQ_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              pkt_done,
    input logic [DATA_W-1:0] pkt_rem_words,
    input logic              fetch_ack,
    input logic              last_pkt,
    input logic              fetch_req,
    input logic [DATA_W-1:0] thr_q,
    input logic [DATA_W-1:0] seq_word
);

    logic seq_w;
    logic fill_done;
    logic take;
    assign seq_w     = reg_wr && (reg_addr == ADDR_W'(ADDR_SEQ));
    assign fill_done = pkt_done && !last_pkt;
    assign take      = last_pkt && fetch_ack;

    AST_SHARE_AREA: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done && !soft_rst && (pkt_rem_words >= thr_q) |=> !last_pkt && !fetch_req); // R1

    AST_CLOSE_AREA: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done && !soft_rst && (thr_q > pkt_rem_words) |=> last_pkt && fetch_req); // R2

    AST_PKT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done && !seq_w |=>
        seq_word[SEQ_W-1:0] == SEQ_W'($past(seq_word[SEQ_W-1:0]) + 1'b1)); // R5

    AST_BUF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        take && !seq_w |=>
        (seq_word[DATA_W-1:SEQ_W] == SEQ_W'($past(seq_word[DATA_W-1:SEQ_W]) + 1'b1))
        && (seq_word[SEQ_W-1:0] == '0) && !last_pkt); // R6

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        last_pkt && !fetch_ack && !soft_rst |=> last_pkt); // R7

    AST_SOFT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !last_pkt && !fetch_req); // R8

    AST_SOFT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst && !reg_wr && !fill_done && !take |=> $stable(seq_word) && $stable(thr_q)); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_w |=> seq_word == $past(reg_wdata)); // R9

endmodule

bind rba_sequencer rba_seq_checker #(
    .SEQ_W   (SEQ_W),
    .ADDR_W  (ADDR_W),
    .ADDR_SEQ(ADDR_SEQ)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .pkt_done     (pkt_done),
    .pkt_rem_words(pkt_rem_words),
    .fetch_ack    (fetch_ack),
    .last_pkt     (last_pkt),
    .fetch_req    (fetch_req),
    .thr_q        (thr_q),
    .seq_word     (seq_word)
);

// File: tb/rba_sequencer_bench.sv
module rba_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        pkt_done = 1'b0;
    logic [15:0] pkt_rem_words = 16'd0;
    logic        last_pkt;
    logic        fetch_req;
    logic        fetch_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int m_thr  = 760;
    int m_pkt  = 0;
    int m_buf  = 0;
    bit m_flag = 0;

    always #4 clk = ~clk;

    rba_sequencer u_rba_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .pkt_done     (pkt_done),
        .pkt_rem_words(pkt_rem_words),
        .last_pkt     (last_pkt),
        .fetch_req    (fetch_req),
        .fetch_ack    (fetch_ack)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(input int a);
        if (a == 0) return m_thr;
        if (a == 1) return (m_buf << 8) | m_pkt;
        return 0;
    endfunction

    task automatic model_step();
        bit accept;
        bit take;
        if (!rst_n) begin
            m_thr = 760; m_pkt = 0; m_buf = 0; m_flag = 0;
            return;
        end
        accept = pkt_done && !m_flag;
        take   = fetch_ack && m_flag;
        if (accept) begin
            m_pkt = (m_pkt + 1) % 256;
            if (m_thr > int'(pkt_rem_words)) m_flag = 1;
        end
        if (take) begin
            m_pkt = 0;
            m_buf = (m_buf + 1) % 256;
            m_flag = 0;
        end
        if (soft_rst) m_flag = 0;
        if (reg_wr && reg_addr == 2'd1) begin
            m_pkt = reg_wdata[7:0];
            m_buf = reg_wdata[15:8];
        end
        if (reg_wr && reg_addr == 2'd0) m_thr = reg_wdata;
    endtask

    // One clock: drive, compare everything against the model, then advance it
    task automatic cyc(input logic wr, input logic [1:0] a, input logic [15:0] wd,
                       input logic dn, input logic [15:0] rem, input logic ak,
                       input logic sf, input string tag);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        pkt_done = dn; pkt_rem_words = rem; fetch_ack = ak; soft_rst = sf;
        #1;
        check({tag, " last_pkt"}, int'(last_pkt), int'(m_flag));
        check({tag, " fetch_req"}, int'(fetch_req), int'(m_flag));
        check({tag, " rdata"}, int'(reg_rdata), model_read(a));
        model_step();
    endtask

    task automatic idle_rd(input logic [1:0] a, input string tag);
        cyc(1'b0, a, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic done(input logic [15:0] rem, input string tag);
        cyc(1'b0, 2'd1, 16'h0, 1'b1, rem, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lfsr;
        // R3: hardware reset values
        repeat (3) idle_rd(2'd0, "R3");
        rst_n = 1'b1;
        idle_rd(2'd0, "R3");
        idle_rd(2'd1, "R3");
        check("R3 threshold reset", int'(reg_rdata), 16'h0000); // addr 1 seq is zero
        idle_rd(2'd0, "R3");
        check("R3 threshold 0x02F8", int'(reg_rdata), 16'h02F8);

        // R1: equality and above keep the area
        done(16'd760, "R1");
        done(16'd1000, "R1");
        idle_rd(2'd1, "R5");
        check("R5 two packets counted", int'(reg_rdata), 16'h0002);
        check("R1 no flag at equality", int'(last_pkt), 0);

        // R2: one below closes the area
        done(16'd759, "R2");
        idle_rd(2'd1, "R2");
        check("R2 flag raised", int'(fetch_req), 1);
        // R7: held without ack, done strobes ignored
        done(16'd0, "R7");
        done(16'd5000, "R7");
        idle_rd(2'd1, "R7");
        check("R7 counters frozen", int'(reg_rdata), 16'h0003);
        // R6: acknowledge
        cyc(1'b0, 2'd1, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, "R6");
        idle_rd(2'd1, "R6");
        check("R6 new area numbering", int'(reg_rdata), 16'h0100);
        check("R6 flag dropped", int'(last_pkt), 0);

        // R10: program threshold, takes effect next packet
        cyc(1'b1, 2'd0, 16'd5, 1'b1, 16'd4, 1'b0, 1'b0, "R10"); // old 760 still applies
        done(16'd4, "R10");
        idle_rd(2'd0, "R10");
        check("R10 threshold readback", int'(reg_rdata), 5);
        cyc(1'b0, 2'd1, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, "R10");
        done(16'd5, "R10");
        idle_rd(2'd1, "R10");
        check("R10 equal keeps area", int'(last_pkt), 0);

        // R5: packet number wraps without touching the buffer number
        cyc(1'b1, 2'd1, 16'h01FE, 1'b0, 16'h0, 1'b0, 1'b0, "R9");
        done(16'd100, "R5");
        done(16'd100, "R5");
        idle_rd(2'd1, "R5");
        check("R5 packet wrap", int'(reg_rdata), 16'h0100);

        // R6: buffer number wraps
        cyc(1'b1, 2'd1, 16'hFF10, 1'b0, 16'h0, 1'b0, 1'b0, "R9");
        done(16'd0, "R6");
        cyc(1'b0, 2'd1, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, "R6");
        idle_rd(2'd1, "R6");
        check("R6 buffer wrap", int'(reg_rdata), 16'h0000);

        // R9: write wins over done strobe and over acknowledge
        cyc(1'b1, 2'd1, 16'h1234, 1'b1, 16'd100, 1'b0, 1'b0, "R9");
        idle_rd(2'd1, "R9");
        check("R9 write over done", int'(reg_rdata), 16'h1234);
        done(16'd1, "R9");
        cyc(1'b1, 2'd1, 16'h0000, 1'b0, 16'h0, 1'b1, 1'b0, "R9");
        idle_rd(2'd1, "R9");
        check("R9 zero write clears", int'(reg_rdata), 16'h0000);

        // R8: software reset drops the pending request, keeps registers
        done(16'd100, "R8");
        done(16'd0, "R8");
        cyc(1'b0, 2'd1, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1, "R8");
        idle_rd(2'd1, "R8");
        check("R8 seq kept", int'(reg_rdata), 16'h0002);
        check("R8 request dropped", int'(fetch_req), 0);
        idle_rd(2'd0, "R8");
        check("R8 threshold kept", int'(reg_rdata), 5);

        // R4: unmapped addresses
        cyc(1'b1, 2'd2, 16'hBEEF, 1'b0, 16'h0, 1'b0, 1'b0, "R4");
        idle_rd(2'd2, "R4");
        check("R4 addr2 zero", int'(reg_rdata), 0);
        idle_rd(2'd3, "R4");
        check("R4 addr3 zero", int'(reg_rdata), 0);

        // Mixed traffic against the model
        lfsr = 32'h1ACE5;
        for (int i = 0; i < 600; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            cyc((lfsr[4:0] == 5'd3), lfsr[6:5] & 2'b01, 16'(lfsr[15:0] & 16'h00FF),
                lfsr[7], 16'(lfsr[12:8]), lfsr[13] & lfsr[14], (lfsr[11:8] == 4'hF), "R1");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule